// File: doc/BRIEF.md
# Almost-Full / Almost-Empty Threshold Loader

This block sits on the write side of a clocked FIFO. It sets up the two threshold values that the FIFO's almost-empty and almost-full flags compare against. `ofs_empty` is the threshold for the almost-empty flag and `ofs_full` is the threshold for the almost-full flag. The block also produces the start-up handshake that keeps the FIFO's input-ready flag low until both thresholds hold valid values.

The load method is chosen by two select pins, which are sampled on the last clock cycle of a reset. Two methods load a fixed constant into both thresholds. The parallel method takes the first two accepted data-port writes and turns them into thresholds instead of storing them in the FIFO. The serial method shifts in one bit per clock cycle on the same two pins, which then act as a strobe and a data line. All logic runs on the write clock with a synchronous active-high reset. The FIFO array is outside this block.

The FIFO write path uses `fifo_wr_en` as its store strobe. The input-ready flag is `prog_done`.

Top module: `flag_offset_loader`

## Requirements
- R1: On the last clock cycle with `rst` high, the block samples the pair {`sel1_sen_n`,`sel0_sdata`}. The encodings are: 2'b11 selects serial load, 2'b10 selects the 64 preset, 2'b01 selects the 8 preset, and 2'b00 selects parallel load.
- R2: While `rst` is high, `prog_done`, `divert_wr` and `fifo_wr_en` are all 0. In the two load modes, both thresholds read 0 until they are loaded.
- R3: A reset that is high for fewer than 4 consecutive cycles is not qualified. After such a reset, `prog_done` stays 0 until a qualified reset has been applied.
- R4: In both preset modes and in parallel mode, `prog_done` is still 0 after the first clock edge following reset release and is 1 after the second. In a preset mode, both thresholds equal the chosen preset.
- R5: In parallel mode, `divert_wr` is 1 from the moment `prog_done` rises. The first accepted write loads `ofs_full` from `wr_data[8:0]`, and the second loads `ofs_empty` from `wr_data[8:0]`. Bit 8 is the MSB and the upper data bits are ignored. `fifo_wr_en` stays 0 for both of these writes.
- R6: Once both parallel writes are done, `divert_wr` is 0 and `fifo_wr_en` follows `wr_req`. In preset modes, `fifo_wr_en` follows `wr_req` as soon as `prog_done` is 1.
- R7: A write request made while `prog_done` is 0 is not accepted. It loads nothing and is not counted as one of the two parallel writes.
- R8: In serial mode, shifting starts from the second edge after release. Each edge with `sel1_sen_n` low shifts in `sel0_sdata`, and edges with `sel1_sen_n` high shift nothing. The 18 bits form {`ofs_full`,`ofs_empty`} and arrive MSB first: the MSB of `ofs_full` is first and the LSB of `ofs_empty` is last.
- R9: In serial mode, `prog_done` is still 0 after the edge that takes the 18th bit. It rises on the next edge, and both thresholds appear on that same edge.
- R10: Any loaded value is clamped into the range 1 to 508. A value of 0 becomes 1, and a value above 508 becomes 508.
- R11: Once `prog_done` is 1 and no diversion is pending, the thresholds and `prog_done` hold until the next reset, whatever the select pins and write port do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| rst | input | 1 | Synchronous active-high reset |
| sel1_sen_n | input | 1 | Mode select high bit at reset; active-low shift strobe in serial mode |
| sel0_sdata | input | 1 | Mode select low bit at reset; serial data bit in serial mode |
| wr_req | input | 1 | Write request on the data port |
| wr_data | input | DATA_W (36) | Write data; bits 8:0 carry a threshold in parallel mode |
| ofs_empty | output | OFS_W (9) | Almost-empty threshold |
| ofs_full | output | OFS_W (9) | Almost-full threshold |
| prog_done | output | 1 | Thresholds ready; drives the input-ready flag |
| divert_wr | output | 1 | The next accepted write loads a threshold instead of being stored |
| fifo_wr_en | output | 1 | Write strobe to FIFO storage |

## Verification
The bench builds the block with its defaults: a depth of 512, 9-bit thresholds, an 18-bit serial word, a 4-cycle reset qualification and a 2-cycle settle time. The 9-bit raw field can hold 509 to 511, so values above the 508 ceiling are reachable, and 0 is reachable as well, so both clamp limits can be exercised from either load path. The short qualification window lets the bench compare a 3-cycle reset with a 4-cycle reset cheaply. The short settle time places the `prog_done` edge at a cycle count the bench can predict for every mode.

// File: rtl/ofl_pkg.sv
package ofl_pkg;

  // pin pair {sel1, sel0} sampled on the last reset cycle
  typedef enum logic [1:0] {
    MODE_PAR    = 2'b00,
    MODE_PRE_LO = 2'b01,
    MODE_PRE_HI = 2'b10,
    MODE_SER    = 2'b11
  } ofl_mode_e;

  typedef enum logic [2:0] {
    ST_RST,
    ST_BADRST,
    ST_SETTLE,
    ST_PAR_Y,
    ST_PAR_X,
    ST_SER,
    ST_RUN
  } ofl_state_e;

endpackage

// File: rtl/ofl_rst_qual.sv
// Samples the mode pins during reset and checks the reset length.
module ofl_rst_qual
  import ofl_pkg::*;
#(
  parameter int RST_CYC = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      sel1,
  input  logic      sel0,
  output ofl_mode_e mode_q,
  output logic      rst_ok
);

  logic [RST_CYC-1:0] hold_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= ofl_mode_e'({sel1, sel0});
      hold_sr <= (hold_sr << 1) | {{(RST_CYC-1){1'b0}}, 1'b1};
    end else begin
      hold_sr <= '0;
    end
  end

  assign rst_ok = &hold_sr;

endmodule

// File: rtl/ofl_serial_shift.sv
// Collects the serial threshold word, MSB first.
module ofl_serial_shift #(
  parameter int BITS = 18
) (
  input  logic            clk,
  input  logic            clr,
  input  logic            en,
  input  logic            din,
  output logic [BITS-1:0] word,
  output logic            full
);

  localparam int CW = $clog2(BITS + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt  <= '0;
      word <= '0;
    end else if (en && !full) begin
      word <= {word[BITS-2:0], din};
      cnt  <= cnt + 1'b1;
    end
  end

  assign full = (cnt == CW'(BITS));

endmodule

// File: rtl/ofl_clamp.sv
// Limits a raw threshold value to [LO, HI].
module ofl_clamp #(
  parameter int W  = 9,
  parameter int LO = 1,
  parameter int HI = 508
) (
  input  logic [W-1:0] raw,
  output logic [W-1:0] lim
);

  always_comb begin
    if (raw < W'(LO))      lim = W'(LO);
    else if (raw > W'(HI)) lim = W'(HI);
    else                   lim = raw;
  end

endmodule

// File: rtl/flag_offset_loader.sv
module flag_offset_loader
  import ofl_pkg::*;
#(
  parameter int DATA_W     = 36,
  parameter int DEPTH      = 512,
  parameter int GUARD      = 4,
  parameter int RST_CYC    = 4,
  parameter int SETTLE_CYC = 2,
  parameter int PRESET_LO  = 8,
  parameter int PRESET_HI  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel1_sen_n,
  input  logic              sel0_sdata,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_data,
  output logic [$clog2(DEPTH)-1:0] ofs_empty,
  output logic [$clog2(DEPTH)-1:0] ofs_full,
  output logic              prog_done,
  output logic              divert_wr,
  output logic              fifo_wr_en
);

  localparam int OFS_W    = $clog2(DEPTH);
  localparam int SER_BITS = 2 * OFS_W;
  localparam int OFS_MIN  = 1;
  localparam int OFS_MAX  = DEPTH - GUARD;
  localparam int SCW      = $clog2(SETTLE_CYC + 1);

  ofl_state_e          state;
  ofl_mode_e           mode_q;
  logic                rst_ok;
  logic [SCW-1:0]      settle;
  logic                ser_en;
  logic                ser_full;
  logic [SER_BITS-1:0] ser_word;
  logic                acc;
  logic                unused_hi;

  // index 1: almost-full (loaded first), index 0: almost-empty
  logic [OFS_W-1:0] raw_v [2];
  logic [OFS_W-1:0] lim_v [2];

  ofl_rst_qual #(.RST_CYC(RST_CYC)) u_qual (
    .clk    (clk),
    .rst    (rst),
    .sel1   (sel1_sen_n),
    .sel0   (sel0_sdata),
    .mode_q (mode_q),
    .rst_ok (rst_ok)
  );

  assign ser_en = (state == ST_SER) && !sel1_sen_n;

  ofl_serial_shift #(.BITS(SER_BITS)) u_shift (
    .clk  (clk),
    .clr  (rst),
    .en   (ser_en),
    .din  (sel0_sdata),
    .word (ser_word),
    .full (ser_full)
  );

  generate
    for (genvar g = 0; g < 2; g++) begin : g_lim
      assign raw_v[g] = (state == ST_SER) ? ser_word[g*OFS_W +: OFS_W]
                                          : wr_data[OFS_W-1:0];
      ofl_clamp #(.W(OFS_W), .LO(OFS_MIN), .HI(OFS_MAX)) u_clamp (
        .raw (raw_v[g]),
        .lim (lim_v[g])
      );
    end
  endgenerate

  assign unused_hi  = ^wr_data[DATA_W-1:OFS_W];
  assign acc        = wr_req && prog_done;
  assign fifo_wr_en = acc && !divert_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_RST;
      prog_done <= 1'b0;
      divert_wr <= 1'b0;
      settle    <= '0;
      case (ofl_mode_e'({sel1_sen_n, sel0_sdata}))
        MODE_PRE_LO: begin
          ofs_empty <= OFS_W'(PRESET_LO);
          ofs_full  <= OFS_W'(PRESET_LO);
        end
        MODE_PRE_HI: begin
          ofs_empty <= OFS_W'(PRESET_HI);
          ofs_full  <= OFS_W'(PRESET_HI);
        end
        default: begin
          ofs_empty <= '0;
          ofs_full  <= '0;
        end
      endcase
    end else begin
      case (state)
        ST_RST: begin
          if (!rst_ok) begin
            state <= ST_BADRST;
          end else if (mode_q == MODE_SER) begin
            state <= ST_SER;
          end else if (SETTLE_CYC <= 1) begin
            prog_done <= 1'b1;
            divert_wr <= (mode_q == MODE_PAR);
            state     <= (mode_q == MODE_PAR) ? ST_PAR_Y : ST_RUN;
          end else begin
            settle <= SCW'(1);
            state  <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          settle <= settle + 1'b1;
          if (settle == SCW'(SETTLE_CYC - 1)) begin
            prog_done <= 1'b1;
            divert_wr <= (mode_q == MODE_PAR);
            state     <= (mode_q == MODE_PAR) ? ST_PAR_Y : ST_RUN;
          end
        end
        ST_PAR_Y: begin
          if (acc) begin
            ofs_full <= lim_v[1];
            state    <= ST_PAR_X;
          end
        end
        ST_PAR_X: begin
          if (acc) begin
            ofs_empty <= lim_v[0];
            divert_wr <= 1'b0;
            state     <= ST_RUN;
          end
        end
        ST_SER: begin
          if (ser_full) begin
            ofs_full  <= lim_v[1];
            ofs_empty <= lim_v[0];
            prog_done <= 1'b1;
            state     <= ST_RUN;
          end
        end
        default: state <= state;
      endcase
    end
  end

endmodule

// File: rtl/ofl_chk.sv
module ofl_chk #(
  parameter int OFS_W   = 9,
  parameter int OFS_MAX = 508
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_req,
  input logic [OFS_W-1:0] wr_lo,
  input logic [OFS_W-1:0] ofs_empty,
  input logic [OFS_W-1:0] ofs_full,
  input logic             prog_done,
  input logic             divert_wr
);

  // R2
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!prog_done && !divert_wr));

  // R5
  divert_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(divert_wr) |-> ($past(wr_req) && $past(prog_done)));

  // R10
  range_chk: assert property (@(posedge clk) disable iff (rst)
    (prog_done && !divert_wr) |->
      (ofs_empty >= OFS_W'(1) && ofs_empty <= OFS_W'(OFS_MAX) &&
       ofs_full  >= OFS_W'(1) && ofs_full  <= OFS_W'(OFS_MAX)));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(prog_done) && !$past(divert_wr) && prog_done) |->
      ($stable(ofs_empty) && $stable(ofs_full)));

  // R11
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    prog_done |=> prog_done);

  // R10: note an out-of-range parallel value that gets limited
  always_ff @(posedge clk) begin
    if (!rst && wr_req && prog_done && divert_wr &&
        (wr_lo == '0 || wr_lo > OFS_W'(OFS_MAX)))
      $display("note: threshold value %0d limited to range", wr_lo);
  end

endmodule

bind flag_offset_loader ofl_chk #(.OFS_W(OFS_W), .OFS_MAX(OFS_MAX)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_req    (wr_req),
  .wr_lo     (wr_data[OFS_W-1:0]),
  .ofs_empty (ofs_empty),
  .ofs_full  (ofs_full),
  .prog_done (prog_done),
  .divert_wr (divert_wr)
);

// File: tb/test_flag_offset_loader.sv
`timescale 1ns/1ps
module test_flag_offset_loader;

  localparam int DW = 36;
  localparam int OW = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel1_sen_n = 1'b0;
  logic sel0_sdata = 1'b0;
  logic wr_req = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [OW-1:0] ofs_empty, ofs_full;
  logic prog_done, divert_wr, fifo_wr_en;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  flag_offset_loader i_flag_offset_loader (
    .clk(clk), .rst(rst), .sel1_sen_n(sel1_sen_n), .sel0_sdata(sel0_sdata),
    .wr_req(wr_req), .wr_data(wr_data), .ofs_empty(ofs_empty),
    .ofs_full(ofs_full), .prog_done(prog_done), .divert_wr(divert_wr),
    .fifo_wr_en(fifo_wr_en)
  );

  // {serial, y_raw, x_raw, y_exp, x_exp}
  localparam logic [36:0] VEC [6] = '{
    {1'b0, 9'd100, 9'd20,  9'd100, 9'd20},
    {1'b0, 9'd0,   9'd509, 9'd1,   9'd508},
    {1'b0, 9'd508, 9'd1,   9'd508, 9'd1},
    {1'b1, 9'd300, 9'd5,   9'd300, 9'd5},
    {1'b1, 9'd511, 9'd0,   9'd508, 9'd1},
    {1'b1, 9'd1,   9'd508, 9'd1,   9'd508}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] pins, input int cycles);
    rst = 1'b1;
    {sel1_sen_n, sel0_sdata} = pins;
    repeat (cycles) tick();
    rst = 1'b0;
  endtask

  task automatic run_main();
    logic [1:0] pins;
    logic [OW-1:0] y, x, ey, ex;
    logic [2*OW-1:0] w;
    // R2: reset state with a write request pending
    wr_req = 1'b1;
    do_reset(2'b01, 6);
    wr_req = 1'b0;
    rst = 1'b1; wr_req = 1'b1; #0;
    chk(prog_done == 0 && divert_wr == 0 && fifo_wr_en == 0, "R2",
        "outputs idle in reset", {prog_done, divert_wr, fifo_wr_en}, 0);
    wr_req = 1'b0;

    for (int i = 0; i < 6; i++) begin
      {pins[0], y, x, ey, ex} = VEC[i];
      if (!pins[0]) begin
        do_reset(2'b00, 4);
        wr_req = 1'b1; wr_data = 36'd77;  // R7: ignored before ready
        tick();
        chk(prog_done == 0, "R4", "parallel done after edge 1", prog_done, 0);
        chk(ofs_full == 0 && ofs_empty == 0, "R2", "unloaded thresholds",
            ofs_full, 0);
        tick();
        chk(prog_done == 1, "R4", "parallel done after edge 2", prog_done, 1);
        wr_data = {{(DW-OW){1'b1}}, y};
        chk(divert_wr == 1 && fifo_wr_en == 0, "R5", "first write diverted",
            {divert_wr, fifo_wr_en}, 2);
        tick();
        wr_data = {{(DW-OW){1'b1}}, x};
        chk(divert_wr == 1 && fifo_wr_en == 0, "R5", "second write diverted",
            {divert_wr, fifo_wr_en}, 2);
        tick();
        wr_req = 1'b0;
        chk(ofs_full == ey, "R7", "almost-full threshold after parallel load",
            ofs_full, ey);
        chk(ofs_empty == ex, "R10", "almost-empty threshold after parallel load",
            ofs_empty, ex);
        chk(divert_wr == 0, "R6", "diversion ends", divert_wr, 0);
        wr_req = 1'b1; #0;
        chk(fifo_wr_en == 1, "R6", "writes reach storage", fifo_wr_en, 1);
        wr_req = 1'b0;
      end else begin
        w = {y, x};
        do_reset(2'b11, 4);
        tick();
        for (int b = 2*OW-1; b >= 0; b--) begin
          if (b == 9) begin  // R8: strobe high shifts nothing
            sel1_sen_n = 1'b1; sel0_sdata = ~w[b];
            tick();
          end
          sel1_sen_n = 1'b0; sel0_sdata = w[b];
          tick();
        end
        chk(prog_done == 0, "R9", "done low after last bit", prog_done, 0);
        chk(ofs_full == 0, "R2", "threshold still unloaded", ofs_full, 0);
        sel1_sen_n = 1'b1;
        tick();
        chk(prog_done == 1, "R9", "done on edge after last bit", prog_done, 1);
        chk(ofs_full == ey, "R8", "serial almost-full threshold", ofs_full, ey);
        chk(ofs_empty == ex, "R10", "serial almost-empty threshold",
            ofs_empty, ex);
      end
    end

    // R1 / R4: preset 8
    do_reset(2'b01, 4);
    tick();
    chk(prog_done == 0, "R4", "preset done after edge 1", prog_done, 0);
    tick();
    chk(prog_done == 1, "R4", "preset done after edge 2", prog_done, 1);
    chk(ofs_empty == 8 && ofs_full == 8, "R1", "preset 8 thresholds",
        ofs_empty, 8);
    wr_req = 1'b1; #0;
    chk(fifo_wr_en == 1 && divert_wr == 0, "R6", "preset writes stored",
        fifo_wr_en, 1);
    wr_req = 1'b0;

    // R1: preset 64, then R11 disturbances
    do_reset(2'b10, 4);
    tick(); tick();
    chk(ofs_empty == 64 && ofs_full == 64, "R1", "preset 64 thresholds",
        ofs_full, 64);
    sel1_sen_n = 1'b0; wr_req = 1'b1; wr_data = 36'd3;
    for (int k = 0; k < 20; k++) begin
      sel0_sdata = k[0];
      tick();
    end
    wr_req = 1'b0;
    chk(ofs_empty == 64 && ofs_full == 64 && prog_done == 1, "R11",
        "thresholds hold in run", ofs_empty, 64);

    // R3: short reset does not qualify
    do_reset(2'b01, 3);
    repeat (4) tick();
    chk(prog_done == 0, "R3", "short reset keeps done low", prog_done, 0);
    do_reset(2'b01, 4);
    tick(); tick();
    chk(prog_done == 1, "R3", "qualified reset recovers", prog_done, 1);
  endtask

  initial begin
    fork
      begin
        @(negedge clk);
        run_main();
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule